// File: doc/BRIEF.md
# Repeating ADC Channel-Sequence Controller

This controller sits between software registers and an external 12-bit converter. Software fills a short list of conversion entries. Each entry names an input channel, and any entry may carry an end-of-sequence marker. When triggered, the controller walks the list. For each entry it sends a request tagged with that entry's channel, waits for the converter's done pulse, and stores the returned value in the result register that belongs to that entry. The list may name channels in any order and may repeat a channel.

A control word selects the run mode. With the multiple-conversion bit set, each conversion follows the previous one with no further trigger. Otherwise each conversion after the first waits for another start. In repeat mode the list restarts at entry 0 after its final entry and runs until software drops the enable bit. Every result register has an interrupt flag and an enable bit. A single interrupt line reports any enabled flag that is set. Reading a result clears its flag.

Register map: bus_addr[4:3] picks a bank and bus_addr[2:0] an index. Bank 0, index 0 is the control word. Bank 0, index 1 is the interrupt-enable mask. Bank 0, index 2 is the flag word (read-only). Bank 1, index n is list entry n. Bank 2, index n is result n. Reads return bus_rdata combinationally from bus_addr. A read of bank 2 with bus_re high applies its side effects at the clock edge.

Top module: `adc_seq_ctrl`

## Requirements
- R1: List entry n holds a channel in bits [3:0] and an end marker in bit 7. The conversion for entry n issues that channel on conv_ch, and its value lands in result n. Repeated channels and any channel order are accepted.
- R2: A pass begins at entry 0 and ends after the first entry whose end marker is set. If no marker is set, it ends after the last entry. With repeat off (control bit 3 = 0), the controller then goes idle.
- R3: With repeat on (control bit 3 = 1), the entry after the final entry is entry 0, and passes continue while enable is set.
- R4: With control bit 2 (multiple) set, the next conversion of a pass is requested after the previous one completes, with no trigger. With it clear, each later conversion waits for a new start write.
- R5: Writing control bit 1 (start) begins a pass only if enable (control bit 0) was already 1 before that write. A start with enable 0, or in the same write that sets enable, does nothing.
- R6: Result n reads as a 16-bit word: the 12-bit value in bits [11:0] with bits [15:12] zero. All results read 0 after reset.
- R7: Storing result n sets flag n (flag word bit n). irq is high exactly when some flag is set whose interrupt-enable bit is also set.
- R8: A read of result n with bus_re clears flag n.
- R9: While enable is 1, writes to list entries and to control bits 2 and 3 are ignored.
- R10: Clearing enable lets an outstanding conversion complete and be stored. After that, no request is issued and the controller goes idle.
- R11: Control bit 4 (busy, read-only) is 1 from the accepted start until the controller returns to idle. It stays 1 while waiting for a start when multiple is clear.
- R12: Control bit 5 (overflow, read-only) is set when a result is stored while its flag is still set, and any result read with bus_re clears it.
- R13: conv_req is a one-cycle pulse, and no further request is issued until the matching done arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (clears flags and overflow on results) |
| bus_addr | input | 5 | Register address: bank in [4:3], index in [2:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Interrupt: any enabled flag set |
| conv_req | output | 1 | One-cycle conversion request |
| conv_ch | output | 4 | Channel of the requested conversion |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result, valid with conv_done |

## Verification
On every cycle, the embedded properties check five things. Requests are single pulses and never follow a cycle with enable low. A store always raises its flag, and a store onto a set flag raises overflow. A read clears its flag unless a store to the same slot coincides. A locked list never changes, and busy only rises from an enabled state. Some behaviours show only in the bench scenarios: the order of channels walked for each end-marker position, the wrap in repeat mode, the trigger-per-conversion pacing, the exact values landing in each result slot, and the orderly stop after enable drops.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_HOLD} seq_state_t;

   localparam int CTL_EN    = 0;
   localparam int CTL_GO    = 1;
   localparam int CTL_MULTI = 2;
   localparam int CTL_REP   = 3;
   localparam int CTL_BUSY  = 4;
   localparam int CTL_OVF   = 5;
   localparam int ENT_EOS   = 7;

   localparam logic [1:0] BANK_MISC = 2'b00;
   localparam logic [1:0] BANK_ENT  = 2'b01;
   localparam logic [1:0] BANK_RES  = 2'b10;

   localparam logic [2:0] MISC_CTRL = 3'd0;
   localparam logic [2:0] MISC_IE   = 3'd1;
   localparam logic [2:0] MISC_IFG  = 3'd2;
endpackage

// File: rtl/seq_entry_bank.sv
module seq_entry_bank #(
   parameter int N_ENT = 4,
   parameter int CH_W  = 4,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [IDX_W-1:0]        widx,
   input  logic [CH_W-1:0]         wch,
   input  logic                    weos,
   input  logic                    lock,
   output logic [N_ENT*CH_W-1:0]   ch_flat,
   output logic [N_ENT-1:0]        eos
);
   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      logic [CH_W-1:0] ch_q;
      logic            eos_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ch_q  <= '0;
            eos_q <= 1'b0;
         end else if (wr && !lock && widx == IDX_W'(g)) begin
            ch_q  <= wch;
            eos_q <= weos;
         end
      end
      assign ch_flat[g*CH_W +: CH_W] = ch_q;
      assign eos[g] = eos_q;
   end

   a_r9_list_locked: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> ($stable(ch_flat) && $stable(eos)));
endmodule

// File: rtl/seq_engine.sv
module seq_engine
   import adc_seq_pkg::*;
#(
   parameter int N_ENT = 4,
   parameter int CH_W  = 4,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    multi,
   input  logic                    rep,
   input  logic                    start,
   input  logic [N_ENT*CH_W-1:0]   ch_flat,
   input  logic [N_ENT-1:0]        eos,
   input  logic                    conv_done,
   output logic                    conv_req,
   output logic [CH_W-1:0]         conv_ch,
   output logic                    store,
   output logic [IDX_W-1:0]        store_idx,
   output logic                    busy
);
   seq_state_t st_q, st_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic last;

   assign last = eos[idx_q] || (idx_q == IDX_W'(N_ENT-1));

   always_comb begin
      st_d  = st_q;
      idx_d = idx_q;
      unique case (st_q)
         ST_IDLE: if (start) begin
            st_d  = ST_ISSUE;
            idx_d = '0;
         end
         ST_ISSUE: st_d = ST_WAIT;
         ST_WAIT: if (conv_done) begin
            if (!en || (last && !rep)) begin
               st_d = ST_IDLE;
            end else begin
               idx_d = last ? '0 : idx_q + 1'b1;
               st_d  = multi ? ST_ISSUE : ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (!en) st_d = ST_IDLE;
            else if (start) st_d = ST_ISSUE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         idx_q <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
      end
   end

   assign conv_req  = (st_q == ST_ISSUE);
   assign conv_ch   = ch_flat[idx_q*CH_W +: CH_W];
   assign store     = (st_q == ST_WAIT) && conv_done;
   assign store_idx = idx_q;
   assign busy      = (st_q != ST_IDLE);

   a_r13_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> !conv_req);
   a_r10_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !conv_req);
   a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   a_r2_single_pass_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (store && eos[store_idx] && !rep) |=> !busy);
endmodule

// File: rtl/result_bank.sv
module result_bank #(
   parameter int N_ENT = 4,
   parameter int RES_W = 12,
   localparam int IDX_W = $clog2(N_ENT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   store,
   input  logic [IDX_W-1:0]       store_idx,
   input  logic [RES_W-1:0]       store_val,
   input  logic                   rd,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [N_ENT*RES_W-1:0] res_flat,
   output logic [N_ENT-1:0]       ifg,
   output logic                   ovf
);
   for (genvar g = 0; g < N_ENT; g++) begin : g_res
      logic [RES_W-1:0] val_q;
      logic             flag_q;
      logic             hit_st, hit_rd;
      assign hit_st = store && store_idx == IDX_W'(g);
      assign hit_rd = rd && rd_idx == IDX_W'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q  <= '0;
            flag_q <= 1'b0;
         end else begin
            if (hit_st) val_q <= store_val;
            if (hit_st) flag_q <= 1'b1;
            else if (hit_rd) flag_q <= 1'b0;
         end
      end
      assign res_flat[g*RES_W +: RES_W] = val_q;
      assign ifg[g] = flag_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf <= 1'b0;
      else if (store && ifg[store_idx]) ovf <= 1'b1;
      else if (rd) ovf <= 1'b0;
   end

   a_r7_flag_on_store: assert property (@(posedge clk) disable iff (!rst_n)
      store |=> ifg[$past(store_idx)]);
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !(store && store_idx == rd_idx)) |=> !ifg[$past(rd_idx)]);
   a_r12_ovf_on_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (store && ifg[store_idx]) |=> ovf);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int N_ENT  = 4,
   parameter int CH_W   = 4,
   parameter int RES_W  = 12,
   parameter int DATA_W = 16,
   localparam int ADDR_W = 5,
   localparam int IDX_W  = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              conv_req,
   output logic [CH_W-1:0]   conv_ch,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_data
);
   if (N_ENT < 2 || N_ENT > 8) begin : g_bad_n
      $error("N_ENT must lie in 2..8");
   end
   if (CH_W < 1 || CH_W > ENT_EOS) begin : g_bad_ch
      $error("CH_W must leave bit 7 free for the end marker");
   end
   if (RES_W >= DATA_W || DATA_W < 8 || N_ENT > DATA_W) begin : g_bad_w
      $error("DATA_W must exceed RES_W and hold one flag per entry");
   end

   logic [1:0] bank;
   logic [2:0] sel;
   logic       idx_ok;
   logic       wr_ctrl, wr_ie, wr_ent, rd_res;
   logic       en_q, multi_q, rep_q, start;
   logic [N_ENT-1:0] ie_q;
   logic [N_ENT*CH_W-1:0]  ch_flat;
   logic [N_ENT-1:0]       eos;
   logic [N_ENT*RES_W-1:0] res_flat;
   logic [N_ENT-1:0]       ifg;
   logic ovf, busy, store;
   logic [IDX_W-1:0] store_idx;
   logic unused_wbits;

   assign bank    = bus_addr[4:3];
   assign sel     = bus_addr[2:0];
   assign idx_ok  = (32'(sel) < N_ENT);
   assign wr_ctrl = bus_we && bank == BANK_MISC && sel == MISC_CTRL;
   assign wr_ie   = bus_we && bank == BANK_MISC && sel == MISC_IE;
   assign wr_ent  = bus_we && bank == BANK_ENT && idx_ok;
   assign rd_res  = bus_re && bank == BANK_RES && idx_ok;
   assign start   = wr_ctrl && bus_wdata[CTL_GO] && en_q;
   assign unused_wbits = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         multi_q <= 1'b0;
         rep_q   <= 1'b0;
         ie_q    <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q <= bus_wdata[CTL_EN];
            if (!en_q) begin
               multi_q <= bus_wdata[CTL_MULTI];
               rep_q   <= bus_wdata[CTL_REP];
            end
         end
         if (wr_ie) ie_q <= bus_wdata[N_ENT-1:0];
      end
   end

   seq_entry_bank #(.N_ENT(N_ENT), .CH_W(CH_W)) u_list (
      .clk(clk), .rst_n(rst_n), .wr(wr_ent), .widx(sel[IDX_W-1:0]),
      .wch(bus_wdata[CH_W-1:0]), .weos(bus_wdata[ENT_EOS]), .lock(en_q),
      .ch_flat(ch_flat), .eos(eos));

   seq_engine #(.N_ENT(N_ENT), .CH_W(CH_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .en(en_q), .multi(multi_q), .rep(rep_q),
      .start(start), .ch_flat(ch_flat), .eos(eos), .conv_done(conv_done),
      .conv_req(conv_req), .conv_ch(conv_ch), .store(store),
      .store_idx(store_idx), .busy(busy));

   result_bank #(.N_ENT(N_ENT), .RES_W(RES_W)) u_res (
      .clk(clk), .rst_n(rst_n), .store(store), .store_idx(store_idx),
      .store_val(conv_data), .rd(rd_res), .rd_idx(sel[IDX_W-1:0]),
      .res_flat(res_flat), .ifg(ifg), .ovf(ovf));

   assign irq = |(ifg & ie_q);

   always_comb begin
      bus_rdata = '0;
      unique case (bank)
         BANK_MISC: begin
            if (sel == MISC_CTRL) begin
               bus_rdata[CTL_EN]    = en_q;
               bus_rdata[CTL_MULTI] = multi_q;
               bus_rdata[CTL_REP]   = rep_q;
               bus_rdata[CTL_BUSY]  = busy;
               bus_rdata[CTL_OVF]   = ovf;
            end else if (sel == MISC_IE) begin
               bus_rdata[N_ENT-1:0] = ie_q;
            end else if (sel == MISC_IFG) begin
               bus_rdata[N_ENT-1:0] = ifg;
            end
         end
         BANK_ENT: if (idx_ok) begin
            bus_rdata[CH_W-1:0] = ch_flat[sel[IDX_W-1:0]*CH_W +: CH_W];
            bus_rdata[ENT_EOS]  = eos[sel[IDX_W-1:0]];
         end
         BANK_RES: if (idx_ok) begin
            bus_rdata[RES_W-1:0] = res_flat[sel[IDX_W-1:0]*RES_W +: RES_W];
         end
         default: bus_rdata = '0;
      endcase
   end

   a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en_q));
   a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ifg != '0));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_we = 1'b0, bus_re = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0, bus_rdata;
   logic irq, conv_req, conv_done = 1'b0;
   logic [3:0] conv_ch;
   logic [11:0] conv_data = '0;

   int checks = 0, fails = 0, cycles = 0;
   int req_n = 0, pend = 0;
   int req_ch [0:255];
   int dat [0:255];
   int chs [0:3] = '{3, 9, 3, 12};

   adc_seq_ctrl uut (.*);

   always #2 clk = ~clk;

   function automatic int fval(int k, int ch);
      return (ch * 256 + k * 13 + 7) % 4096;
   endfunction

   // converter model: fixed latency of three cycles
   always @(negedge clk) begin
      conv_done = 1'b0;
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            conv_done = 1'b1;
            conv_data = 12'(dat[req_n-1]);
         end
      end
      if (conv_req && req_n < 256) begin
         req_ch[req_n] = int'(conv_ch);
         dat[req_n] = fval(req_n, int'(conv_ch));
         req_n++;
         pend = 3;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 5'(a); bus_wdata = 16'(d);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic peek(input int a, output int d);
      @(negedge clk);
      bus_addr = 5'(a);
      #1 d = int'(bus_rdata);
   endtask

   task automatic rd(input int a, output int d);
      @(negedge clk);
      bus_addr = 5'(a); bus_re = 1'b1;
      #1 d = int'(bus_rdata);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic wait_idle();
      int v;
      for (int i = 0; i < 300; i++) begin
         peek(0, v);
         if (((v >> 4) & 1) == 0) break;
      end
   endtask

   initial begin
      int v, base, cnt, n0, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      peek(0, v);  chk("R11 ctrl after reset", v, 0);
      peek(2, v);  chk("R7 flags after reset", v, 0);
      peek(16, v); chk("R6 result after reset", v, 0);
      chk("R7 irq after reset", int'(irq), 0);
      chk("R13 no request after reset", req_n, 0);

      // sweep end-marker position 0..3 and none (4)
      for (int p = 0; p < 5; p++) begin
         for (int n = 0; n < 4; n++) wr(8 + n, chs[n] | ((n == p) ? 8'h80 : 0));
         for (int n = 0; n < 4; n++) begin
            peek(8 + n, v);
            chk("R1 entry readback", v, chs[n] | ((n == p) ? 8'h80 : 0));
         end
         cnt = (p < 4) ? p + 1 : 4;
         wr(1, 1 << (cnt - 1));
         wr(0, 4); wr(0, 5);
         base = req_n;
         wr(0, 7);
         peek(0, v); chk("R11 busy after start", (v >> 4) & 1, 1);
         wait_idle();
         chk("R2 pass length", req_n - base, cnt);
         for (int n = 0; n < cnt; n++) chk("R1 channel order", req_ch[base + n], chs[n]);
         peek(2, v); chk("R7 flags after pass", v, (1 << cnt) - 1);
         chk("R7 irq on enabled flag", int'(irq), 1);
         for (int n = 0; n < cnt; n++) begin
            rd(16 + n, v); chk("R6 result value", v, dat[base + n]);
         end
         chk("R8 irq after reads", int'(irq), 0);
         peek(2, v); chk("R8 flags cleared", v, 0);
         wr(0, 4);
      end

      // start gating
      base = req_n;
      wr(0, 6); repeat (10) @(negedge clk);
      chk("R5 start without enable", req_n - base, 0);
      peek(0, v); chk("R5 idle after ignored start", (v >> 4) & 1, 0);
      wr(0, 7); repeat (10) @(negedge clk);
      chk("R5 start with enable in same write", req_n - base, 0);
      peek(0, v); chk("R5 enable now set", v & 1, 1);

      // locks while enabled
      wr(8, 16'h85);
      peek(8, v); chk("R9 entry locked", v, chs[0]);
      wr(0, 9);
      peek(0, v); chk("R9 mode locked", v, 5);
      wr(0, 4);
      wr(8, 16'h85);
      peek(8, v); chk("R9 entry writable when off", v, 16'h85);
      wr(8, chs[0]);

      // one conversion per trigger
      wr(10, chs[2] | 8'h80);
      wr(0, 0); wr(0, 1);
      base = req_n;
      wr(0, 3); repeat (15) @(negedge clk);
      chk("R4 one conversion per trigger", req_n - base, 1);
      peek(0, v); chk("R11 busy while holding", (v >> 4) & 1, 1);
      wr(0, 3); repeat (15) @(negedge clk);
      chk("R4 second trigger", req_n - base, 2);
      wr(0, 3); wait_idle();
      chk("R4 third trigger ends pass", req_n - base, 3);
      chk("R1 channel in paced pass", req_ch[base + 2], chs[2]);
      for (int n = 0; n < 3; n++) begin
         rd(16 + n, v); chk("R6 paced result", v, dat[base + n]);
      end
      wr(0, 0);

      // repeat mode, overflow, orderly stop
      wr(0, 12); wr(0, 13);
      base = req_n;
      wr(0, 15);
      for (int i = 0; i < 400 && req_n < base + 5; i++) @(negedge clk);
      peek(0, v); chk("R12 overflow on second pass", (v >> 5) & 1, 1);
      for (int i = 0; i < 400 && req_n < base + 7; i++) @(negedge clk);
      for (int k = 0; k < 7; k++) chk("R3 wrap order", req_ch[base + k], chs[k % 3]);
      wr(0, 0);
      #1 n0 = req_n;
      wait_idle();
      chk("R10 no request after disable", req_n, n0);
      peek(0, v); chk("R10 idle after disable", (v >> 4) & 1, 0);
      e = (n0 - 1 - base) % 3;
      peek(16 + e, v); chk("R10 last conversion stored", v, dat[n0 - 1]);
      rd(16, v);
      peek(0, v); chk("R12 overflow cleared by read", (v >> 5) & 1, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule